// File: doc/BRIEF.md
# Serial ADC Interface Front End

This block is the device-side digital logic of a 10-bit serial analog-to-digital converter used with an externally supplied serial clock. A host lowers the chip select and clocks a control byte into the data input. The byte opens with a start bit, which the block finds by skipping leading zeros. The block decodes the byte into a channel select, a polarity flag, an input-configuration flag and a two-bit clock-mode code. It raises an acquire output while the last three control bits arrive.

When the clock-mode code selects external clocking, the block pulses a strobe for one serial-clock period. It then shifts out the conversion code supplied on an input port, most significant bit first, one bit per falling serial-clock edge. Two sub-bits and then zeros follow the code. Both serial outputs are released whenever chip select is high, and a high chip select also abandons any transaction in progress.

All logic runs on one fast system clock, and the serial clock is oversampled. Each serial-clock phase must last at least two system clocks.

Top module: `sadc_frontend`

## Requirements
- R1: Reset (`rst_n` low at a `clk` edge) clears `dout`, `sstrb`, `acquire`, `ctrl_valid`, `dout_oe` and `sstrb_oe` to 0.
- R2: While chip select is low, zeros on `din` before the first 1 are ignored, so nothing is captured. The first 1 sampled on a rising `sclk` edge is the start bit of the control byte.
- R3: DIN is sampled on rising `sclk` edges. After the eighth control bit, `ctrl_valid` goes high and stays high until chip select rises. The control byte is decoded as follows: bits [6:4] go to `chan_sel`, bit 3 to `unipolar` (1 = unipolar), bit 2 to `single_ended` (1 = single-ended) and bits [1:0] to `clk_mode`.
- R4: `acquire` rises at the falling `sclk` edge after the fifth control bit, including the start bit. It stays high for exactly three `sclk` periods and drops at the falling edge after the eighth bit.
- R5: With `clk_mode` = 2'b11, `sstrb` rises at the falling `sclk` edge after the eighth control bit. It falls at the next falling edge and changes only on falling edges.
- R6: `dout` is 0 from the start of the control byte until the first result bit. The 10 result bits then appear MSB first, one per falling `sclk` edge, starting at the edge on which `sstrb` falls.
- R7: In unipolar mode the result is `conv_code` unchanged, which is straight binary. In bipolar mode the result is `conv_code` with its MSB inverted: the input is offset binary and the output is two's complement.
- R8: After the tenth result bit, `dout` carries `conv_sub[1]`, then `conv_sub[0]`, then 0 on every later falling edge.
- R9: One `clk` after `cs_n` is seen high, `dout_oe` and `sstrb_oe` are 0 and `dout`, `sstrb`, `acquire` and `ctrl_valid` are cleared. A transaction cut short this way leaves no effect on the next one.
- R10: With `clk_mode` other than 2'b11, no strobe and no result are produced. The block hunts for a new start bit within the same chip-select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control data from the host |
| conv_code | input | 10 | Conversion code in offset binary |
| conv_sub | input | 2 | Sub-bits sent after the code |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for dout |
| sstrb | output | 1 | Conversion strobe |
| sstrb_oe | output | 1 | Output enable for sstrb |
| acquire | output | 1 | Track/hold acquisition window |
| ctrl_valid | output | 1 | A control byte has been captured |
| chan_sel | output | 3 | Decoded channel select |
| unipolar | output | 1 | Decoded polarity flag |
| single_ended | output | 1 | Decoded input-configuration flag |
| clk_mode | output | 2 | Decoded clock-mode code |

## Verification
Every serial-clock event shows up at the outputs one system clock after the clock on which the edge is detected. The bench therefore holds each serial phase for four system clocks and samples at the end of each low phase. At that point the outputs show the falling edge that closed the previous serial cycle. The acquire window is due at samples five to seven after the start bit, the strobe at sample eight, result bits at samples nine to eighteen and sub-bits at samples nineteen and twenty, all counted from the start bit. Output release is checked two system clocks after chip select rises.

// File: rtl/sadc_pkg.sv
// Package: shared constants and types for the serial ADC front end.
// Assumes an 8-bit control byte whose start bit is its MSB.
package sadc_pkg;

    localparam int CTRL_W    = 8;
    localparam int FIELD_W   = CTRL_W - 1;
    localparam int CHAN_HI   = 6;
    localparam int CHAN_LO   = 4;
    localparam int UNI_POS   = 3;
    localparam int SGL_POS   = 2;
    localparam int MODE_HI   = 1;
    localparam int MODE_LO   = 0;
    localparam int ACQ_FIRST = 5;

    localparam logic [1:0] MODE_EXT = 2'b11;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_SHIFT,
        RX_HOLD
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ARMED,
        TX_STROBE,
        TX_SHIFT
    } tx_state_t;

endpackage

// File: rtl/sadc_sclk_edge.sv
// Module: turns the oversampled serial clock into one-cycle rise and fall
// events. Assumes sclk already lies in the clk domain and that each phase
// lasts at least two clk cycles.
module sadc_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);

    logic sclk_q;

    // Purpose: hold the previous sample of sclk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
        end
    end

    // Purpose: flag a change of level between samples.
    always_comb begin
        rise = sclk & ~sclk_q;
        fall = ~sclk & sclk_q;
    end

endmodule

// File: rtl/sadc_ctrl_rx.sv
// Module: hunts for the start bit, shifts in the remaining control bits on
// rising edges, and drives the acquire window on falling edges.
// Assumes clr is held high while chip select is inactive.
module sadc_ctrl_rx
    import sadc_pkg::*;
#(
    parameter int BYTE_W  = CTRL_W,
    parameter int ACQ_BIT = ACQ_FIRST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    output logic              byte_done,
    output logic [BYTE_W-2:0] fields,
    output logic              acquire
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam int SR_W  = BYTE_W - 2;

    rx_state_t        state;
    logic [CNT_W-1:0] bit_cnt;
    logic [SR_W-1:0]  shreg;
    logic [1:0]       mode_bits;

    // Purpose: the clock-mode code is formed by the last stored bit and the incoming bit.
    always_comb begin
        mode_bits = {shreg[0], din};
    end

    // Purpose: start-bit hunt, bit counting and byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state     <= RX_HUNT;
            bit_cnt   <= '0;
            shreg     <= '0;
            fields    <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                case (state)
                    RX_HUNT: begin
                        if (din) begin
                            state   <= RX_SHIFT;
                            bit_cnt <= CNT_W'(1);
                            shreg   <= '0;
                        end
                    end
                    RX_SHIFT: begin
                        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                            fields    <= {shreg, din};
                            byte_done <= 1'b1;
                            bit_cnt   <= '0;
                            state     <= (mode_bits == MODE_EXT) ? RX_HOLD : RX_HUNT;
                        end else begin
                            shreg   <= {shreg[SR_W-2:0], din};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    default: begin
                        state <= RX_HOLD;
                    end
                endcase
            end
        end
    end

    // Purpose: the acquire window follows the bit count, updated on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acquire <= 1'b0;
        end else if (fall) begin
            acquire <= (state == RX_SHIFT) && (bit_cnt >= CNT_W'(ACQ_BIT));
        end
    end

endmodule

// File: rtl/sadc_result_tx.sv
// Module: formats the conversion word, gives a one-period strobe, then
// shifts code, sub-bits and zeros out on falling edges.
// Assumes start arrives between the last control rise and the next fall.
module sadc_result_tx
    import sadc_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int SUB_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fall,
    input  logic              start,
    input  logic              bipolar,
    input  logic [CODE_W-1:0] code,
    input  logic [SUB_W-1:0]  sub,
    output logic              sstrb,
    output logic              dout
);

    localparam int WORD_W = CODE_W + SUB_W;
    localparam logic [CODE_W-1:0] SIGN_FLIP = {1'b1, {(CODE_W-1){1'b0}}};

    tx_state_t         state;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] shreg;

    // Purpose: pick straight binary or two's complement, then append sub-bits.
    always_comb begin
        word = {(bipolar ? (code ^ SIGN_FLIP) : code), sub};
    end

    // Purpose: sequence the strobe and the serial result.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= TX_IDLE;
            shreg <= '0;
            sstrb <= 1'b0;
            dout  <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        shreg <= word;
                        state <= TX_ARMED;
                    end
                end
                TX_ARMED: begin
                    if (fall) begin
                        sstrb <= 1'b1;
                        state <= TX_STROBE;
                    end
                end
                TX_STROBE: begin
                    if (fall) begin
                        sstrb <= 1'b0;
                        dout  <= shreg[WORD_W-1];
                        shreg <= {shreg[WORD_W-2:0], 1'b0};
                        state <= TX_SHIFT;
                    end
                end
                default: begin
                    if (fall) begin
                        dout  <= shreg[WORD_W-1];
                        shreg <= {shreg[WORD_W-2:0], 1'b0};
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sadc_frontend.sv
// Module: top of the serial ADC front end. Ties edge detection, control
// capture and result transmission together, decodes the control fields and
// registers the output enables. Assumes all inputs are synchronous to clk.
module sadc_frontend
    import sadc_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int SUB_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic [CODE_W-1:0] conv_code,
    input  logic [SUB_W-1:0]  conv_sub,
    output logic              dout,
    output logic              dout_oe,
    output logic              sstrb,
    output logic              sstrb_oe,
    output logic              acquire,
    output logic              ctrl_valid,
    output logic [2:0]        chan_sel,
    output logic              unipolar,
    output logic              single_ended,
    output logic [1:0]        clk_mode
);

    logic               rise;
    logic               fall;
    logic               byte_done;
    logic [FIELD_W-1:0] fields;
    logic               tx_start;

    sadc_sclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .rise  (rise),
        .fall  (fall)
    );

    sadc_ctrl_rx #(
        .BYTE_W  (CTRL_W),
        .ACQ_BIT (ACQ_FIRST)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cs_n),
        .rise      (rise),
        .fall      (fall),
        .din       (din),
        .byte_done (byte_done),
        .fields    (fields),
        .acquire   (acquire)
    );

    // Purpose: decode the captured control fields.
    always_comb begin
        chan_sel     = fields[CHAN_HI:CHAN_LO];
        unipolar     = fields[UNI_POS];
        single_ended = fields[SGL_POS];
        clk_mode     = fields[MODE_HI:MODE_LO];
        tx_start     = byte_done && (clk_mode == MODE_EXT);
    end

    sadc_result_tx #(
        .CODE_W (CODE_W),
        .SUB_W  (SUB_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cs_n),
        .fall    (fall),
        .start   (tx_start),
        .bipolar (~unipolar),
        .code    (conv_code),
        .sub     (conv_sub),
        .sstrb   (sstrb),
        .dout    (dout)
    );

    // Purpose: remember that a control byte was captured in this window.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            ctrl_valid <= 1'b0;
        end else if (byte_done) begin
            ctrl_valid <= 1'b1;
        end
    end

    // Purpose: drive the serial outputs only while chip select is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_oe  <= 1'b0;
            sstrb_oe <= 1'b0;
        end else begin
            dout_oe  <= ~cs_n;
            sstrb_oe <= ~cs_n;
        end
    end

endmodule

// File: rtl/sadc_frontend_chk.sv
// Module: timing checks on the front end's ports, attached by bind.
// Keeps its own copy of sclk to see falling edges independently.
module sadc_frontend_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic dout,
    input logic dout_oe,
    input logic sstrb,
    input logic sstrb_oe,
    input logic acquire,
    input logic ctrl_valid
);

    logic sclk_prev;
    logic fall_evt;

    // Purpose: previous sclk sample for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk;
        end
    end

    // Purpose: a falling serial edge is seen at this sample.
    always_comb begin
        fall_evt = sclk_prev && !sclk;
    end

    a_r5_strobe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sstrb) |-> $past(fall_evt));

    a_r6_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$stable(dout)) |-> $past(fall_evt));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout_oe && !sstrb_oe && !dout && !sstrb && !acquire));

    a_r4_acq_strobe_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(acquire && sstrb));

    a_r3_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_valid && !cs_n) |=> ctrl_valid);

endmodule

bind sadc_frontend sadc_frontend_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .sstrb      (sstrb),
    .sstrb_oe   (sstrb_oe),
    .acquire    (acquire),
    .ctrl_valid (ctrl_valid)
);

// File: tb/sadc_frontend_tb.sv
module sadc_frontend_tb;

    localparam int H = 4;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [9:0] code;
        logic [1:0] sub;
        logic [3:0] lead;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'hBF, 10'h2A5, 2'b10, 4'd0},
        '{8'hC3, 10'h3FF, 2'b01, 4'd2},
        '{8'hF7, 10'h000, 2'b11, 4'd5},
        '{8'h8F, 10'h200, 2'b00, 4'd1},
        '{8'hAB, 10'h155, 2'b10, 4'd3},
        '{8'hBD, 10'h3AA, 2'b11, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       din = 1'b0;
    logic [9:0] conv_code = '0;
    logic [1:0] conv_sub = '0;
    logic       dout, dout_oe, sstrb, sstrb_oe, acquire, ctrl_valid;
    logic [2:0] chan_sel;
    logic       unipolar, single_ended;
    logic [1:0] clk_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sadc_frontend u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk         (sclk),
        .cs_n         (cs_n),
        .din          (din),
        .conv_code    (conv_code),
        .conv_sub     (conv_sub),
        .dout         (dout),
        .dout_oe      (dout_oe),
        .sstrb        (sstrb),
        .sstrb_oe     (sstrb_oe),
        .acquire      (acquire),
        .ctrl_valid   (ctrl_valid),
        .chan_sel     (chan_sel),
        .unipolar     (unipolar),
        .single_ended (single_ended),
        .clk_mode     (clk_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One serial cycle: low phase with din set, sample, then high phase.
    task automatic one_cycle(input logic d);
        din = d;
        repeat (H) @(negedge clk);
    endtask

    task automatic high_phase();
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic run_frame(input logic pre_en, input logic [7:0] pre, input vec_t v);
        int   p;
        int   total;
        logic ext;
        logic bip;
        logic [11:0] word;
        p     = pre_en ? 8 : 0;
        total = p + int'(v.lead) + 8 + 16;
        ext   = (v.ctrl[1:0] == 2'b11);
        bip   = ~v.ctrl[3];
        word  = {(bip ? (v.code ^ 10'h200) : v.code), v.sub};
        conv_code = v.code;
        conv_sub  = v.sub;
        cs_n = 1'b0;
        for (int n = 0; n < total; n++) begin
            int   rel;
            logic d;
            logic exp_d;
            rel = n - p - int'(v.lead);
            if (pre_en && n < 8) d = pre[7-n];
            else if (rel >= 0 && rel < 8) d = v.ctrl[7-rel];
            else d = 1'b0;
            one_cycle(d);
            chk("R4 acquire window", 32'(acquire),
                32'(((rel >= 5) && (rel <= 7)) || (pre_en && n >= 5 && n <= 7)));
            if (ext) chk("R5 strobe", 32'(sstrb), 32'(rel == 8));
            else     chk("R10 no strobe", 32'(sstrb), 32'd0);
            exp_d = (ext && rel >= 9 && rel <= 20) ? word[20-rel] : 1'b0;
            if (!ext)           chk("R10 no result", 32'(dout), 32'(exp_d));
            else if (rel < 9)   chk("R6 dout low before result", 32'(dout), 32'(exp_d));
            else if (rel <= 18) chk(bip ? "R7 R6 bipolar result bit" : "R7 R6 unipolar result bit",
                                    32'(dout), 32'(exp_d));
            else                chk("R8 sub-bits then zeros", 32'(dout), 32'(exp_d));
            if (!pre_en && rel == 0) chk("R2 nothing captured before start", 32'(ctrl_valid), 32'd0);
            if (rel == 9) begin
                chk("R3 ctrl_valid", 32'(ctrl_valid), 32'd1);
                chk("R3 chan_sel", 32'(chan_sel), 32'(v.ctrl[6:4]));
                chk("R3 unipolar", 32'(unipolar), 32'(v.ctrl[3]));
                chk("R3 single_ended", 32'(single_ended), 32'(v.ctrl[2]));
                chk("R3 clk_mode", 32'(clk_mode), 32'(v.ctrl[1:0]));
                chk("R9 outputs enabled", 32'({dout_oe, sstrb_oe}), 32'd3);
            end
            high_phase();
        end
        cs_n = 1'b1;
        din  = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 released after cs high", 32'({dout_oe, sstrb_oe, dout, sstrb, ctrl_valid}), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset outputs", 32'({dout, dout_oe, sstrb, sstrb_oe, acquire, ctrl_valid}), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table of frames.
        for (int i = 0; i < NV; i++) begin
            run_frame(1'b0, 8'h00, VECS[i]);
            repeat (3) @(negedge clk);
        end

        // R10: non-external byte, then an external byte in the same window.
        run_frame(1'b1, 8'hBD, '{8'hBF, 10'h0F3, 2'b01, 4'd0});
        repeat (3) @(negedge clk);

        // R9: abort part way through the control byte.
        cs_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            one_cycle(VECS[0].ctrl[7-k]);
            high_phase();
        end
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 abort clears acquire and capture", 32'({acquire, ctrl_valid, dout_oe}), 32'd0);
        run_frame(1'b0, 8'h00, '{8'hB7, 10'h1C4, 2'b10, 4'd1});

        // R1: reset in the middle of a result.
        cs_n = 1'b0;
        for (int k = 0; k < 12; k++) begin
            one_cycle(k < 8 ? VECS[0].ctrl[7-k] : 1'b0);
            high_phase();
        end
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset mid frame", 32'({dout, dout_oe, sstrb, sstrb_oe, acquire, ctrl_valid}), 32'd0);
        cs_n = 1'b1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule